// File: doc/BRIEF.md
# Snooping Write-Through Cache Coherence Controller

This block controls a small direct-mapped, write-through data cache in a multiprocessor where several processors share a single bus. Each cache line holds one data word, a tag and one coherence bit: the line is either valid or invalid. The controller serves reads and writes from its own processor. It fetches missing words from shared memory over a bus master port, and it copies every write onto the bus so that memory always holds the newest value.

At the same time the controller watches a snoop port that shows every bus transaction, tagged with the ID of the requester. It reacts to writes by other processors to a word it holds. The build-time parameter `UPDATE_MODE` selects the reaction. With 0 the local copy is dropped, so the next local read fetches it again. With 1 the snooped data is written into the line and the line stays valid.

The processor port uses a ready/valid handshake. It accepts no new request while a fill or a write-through is waiting on the bus. An address splits into an index (the low `IDX_W` bits) and a tag (the remaining upper bits).

Top module: `snp_wt_ctrl`

## Requirements
- R1: After reset every line is invalid, `cpu_req_ready` is 1, and neither `bus_req_valid` nor `cpu_rsp_valid` is asserted. The first read of any address therefore goes to the bus.
- R2: A read whose index holds a valid line with a matching tag raises `cpu_rsp_valid` with the cached word on the cycle after acceptance. It issues no bus transaction and leaves the line valid.
- R3: A read that misses raises `bus_req_valid` with `bus_req_write`=0 on the cycle after acceptance. When `bus_ack` arrives, the line is filled with `bus_rdata` and made valid, and `cpu_rsp_valid` returns that word on the following cycle.
- R4: Every accepted write raises `bus_req_valid` with `bus_req_write`=1, the request address and the request data on the cycle after acceptance. One cycle after `bus_ack`, a response is given. The line then holds the written word and is valid, so a following read of that address hits.
- R5: While a bus request is outstanding, `cpu_req_ready` is 0. The bus address, data and direction stay unchanged until `bus_ack`.
- R6: A fill or write to an index that holds a different tag replaces the old line. A later read of the old address misses.
- R7: With `UPDATE_MODE`=0, a snooped write (`snp_write`=1) from another requester to an address held valid makes that line invalid. The next local read of that address misses.
- R8: With `UPDATE_MODE`=1, such a snooped write puts `snp_wdata` into the line, which stays valid. The next local read hits and returns the snooped word.
- R9: A snoop is ignored in three cases: its `snp_id` equals the parameter `MY_ID`, it is a read (`snp_write`=0), or its tag differs from the tag held at that index.
- R10: When a snoop hit and a local read to the same index are presented in the same cycle, the snoop is applied first. The read sees the line as it is after the snoop: it misses in invalidate mode, and it hits and returns the snooped word in update mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Controller can accept a request |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rsp_rdata | output | DATA_W | Read data (echo of written data for writes) |
| bus_req_valid | output | 1 | Bus request outstanding |
| bus_req_write | output | 1 | 1 = write-through, 0 = fill read |
| bus_req_addr | output | ADDR_W | Bus address |
| bus_req_wdata | output | DATA_W | Bus write data |
| bus_ack | input | 1 | One-cycle completion from memory |
| bus_rdata | input | DATA_W | Fill data, valid with `bus_ack` |
| snp_valid | input | 1 | A bus transaction is visible |
| snp_write | input | 1 | Snooped transaction is a write |
| snp_id | input | ID_W | Requester ID of the snooped transaction |
| snp_addr | input | ADDR_W | Snooped address |
| snp_wdata | input | DATA_W | Snooped write data |

## Verification
The hardest case to reach is the one in R10: a remote write to a held line must arrive on exactly the clock edge at which a local read of that index is accepted. The directed access task can raise the snoop at the same falling edge at which it raises the request, while the controller is idle, so both meet at the same rising edge. Two instances, one per mode, receive identical stimulus. Each has its own memory model that counts fill reads. A hit and a miss can return the same word, so the difference between the modes is seen in those fill counts and not only in the returned data.

// File: rtl/snp_pkg.sv
package snp_pkg;
  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_FILL  = 2'd1,
    CS_WRITE = 2'd2
  } ctl_state_t;
endpackage

// File: rtl/snp_line_store.sv
module snp_line_store #(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic [IDX_W-1:0]  sn_idx,
  output logic              sn_valid,
  output logic [TAG_W-1:0]  sn_tag,
  input  logic              kill_en,
  input  logic              patch_en,
  input  logic [DATA_W-1:0] patch_data,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data
);
  localparam int LINES = 1 << IDX_W;

  logic              v_arr [LINES];
  logic [TAG_W-1:0]  t_arr [LINES];
  logic [DATA_W-1:0] d_arr [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic              v_q;
    logic [TAG_W-1:0]  t_q;
    logic [DATA_W-1:0] d_q;
    // snoop effect first, local fill last (local access is ordered after snoop)
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        t_q <= '0;
        d_q <= '0;
      end else begin
        if (kill_en && sn_idx == IDX_W'(g)) v_q <= 1'b0;
        if (patch_en && sn_idx == IDX_W'(g)) d_q <= patch_data;
        if (fill_en && fill_idx == IDX_W'(g)) begin
          v_q <= 1'b1;
          t_q <= fill_tag;
          d_q <= fill_data;
        end
      end
    end
    assign v_arr[g] = v_q;
    assign t_arr[g] = t_q;
    assign d_arr[g] = d_q;
  end

  assign rd_valid = v_arr[rd_idx];
  assign rd_tag   = t_arr[rd_idx];
  assign rd_data  = d_arr[rd_idx];
  assign sn_valid = v_arr[sn_idx];
  assign sn_tag   = t_arr[sn_idx];
endmodule

// File: rtl/snp_filter.sv
module snp_filter #(
  parameter int TAG_W       = 6,
  parameter int ID_W        = 2,
  parameter int MY_ID       = 0,
  parameter bit UPDATE_MODE = 1'b0
) (
  input  logic             snp_valid,
  input  logic             snp_write,
  input  logic [ID_W-1:0]  snp_id,
  input  logic [TAG_W-1:0] snp_tag,
  input  logic             line_valid,
  input  logic [TAG_W-1:0] line_tag,
  output logic             kill,
  output logic             patch
);
  logic remote_hit;
  assign remote_hit = snp_valid && snp_write && (snp_id != ID_W'(MY_ID))
                      && line_valid && (line_tag == snp_tag);

  if (UPDATE_MODE) begin : g_update
    assign patch = remote_hit;
    assign kill  = 1'b0;
  end else begin : g_invalidate
    assign kill  = remote_hit;
    assign patch = 1'b0;
  end
endmodule

// File: rtl/snp_wt_ctrl.sv
module snp_wt_ctrl #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int IDX_W       = 2,
  parameter int ID_W        = 2,
  parameter int MY_ID       = 0,
  parameter bit UPDATE_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              bus_req_valid,
  output logic              bus_req_write,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [DATA_W-1:0] bus_req_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic              snp_write,
  input  logic [ID_W-1:0]   snp_id,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [DATA_W-1:0] snp_wdata
);
  import snp_pkg::*;
  localparam int TAG_W = ADDR_W - IDX_W;

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  ctl_state_t        state_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [DATA_W-1:0] pend_wdata_q;
  logic              rsp_v_q;
  logic [DATA_W-1:0] rsp_d_q;

  logic              rd_valid, sn_valid;
  logic [TAG_W-1:0]  rd_tag, sn_tag;
  logic [DATA_W-1:0] rd_data;

  // named events for the checker
  logic ev_accept, ev_hit, ev_snp_kill, ev_snp_patch, ev_fill_done, ev_wt_done;
  logic same_idx, lcl_valid;
  logic [DATA_W-1:0] lcl_data;
  logic fill_en;
  logic [DATA_W-1:0] fill_data;

  snp_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(idx_of(cpu_req_addr)), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_data(rd_data),
    .sn_idx(idx_of(snp_addr)), .sn_valid(sn_valid), .sn_tag(sn_tag),
    .kill_en(ev_snp_kill), .patch_en(ev_snp_patch), .patch_data(snp_wdata),
    .fill_en(fill_en), .fill_idx(idx_of(pend_addr_q)), .fill_tag(tag_of(pend_addr_q)),
    .fill_data(fill_data)
  );

  snp_filter #(.TAG_W(TAG_W), .ID_W(ID_W), .MY_ID(MY_ID), .UPDATE_MODE(UPDATE_MODE)) u_filter (
    .snp_valid(snp_valid), .snp_write(snp_write), .snp_id(snp_id),
    .snp_tag(tag_of(snp_addr)), .line_valid(sn_valid), .line_tag(sn_tag),
    .kill(ev_snp_kill), .patch(ev_snp_patch)
  );

  // local lookup sees the line as it will be after this cycle's snoop
  assign same_idx  = idx_of(snp_addr) == idx_of(cpu_req_addr);
  assign lcl_valid = rd_valid && !(ev_snp_kill && same_idx);
  assign lcl_data  = (ev_snp_patch && same_idx) ? snp_wdata : rd_data;

  assign cpu_req_ready = (state_q == CS_IDLE);
  assign ev_accept     = cpu_req_valid && cpu_req_ready;
  assign ev_hit        = lcl_valid && (rd_tag == tag_of(cpu_req_addr));
  assign ev_fill_done  = (state_q == CS_FILL) && bus_ack;
  assign ev_wt_done    = (state_q == CS_WRITE) && bus_ack;

  assign fill_en   = ev_fill_done || ev_wt_done;
  assign fill_data = ev_wt_done ? pend_wdata_q : bus_rdata;

  assign bus_req_valid = (state_q != CS_IDLE);
  assign bus_req_write = (state_q == CS_WRITE);
  assign bus_req_addr  = pend_addr_q;
  assign bus_req_wdata = pend_wdata_q;
  assign cpu_rsp_valid = rsp_v_q;
  assign cpu_rsp_rdata = rsp_d_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= CS_IDLE;
      pend_addr_q  <= '0;
      pend_wdata_q <= '0;
      rsp_v_q      <= 1'b0;
      rsp_d_q      <= '0;
    end else begin
      rsp_v_q <= 1'b0;
      unique case (state_q)
        CS_IDLE: if (ev_accept) begin
          if (!cpu_req_write && ev_hit) begin
            rsp_v_q <= 1'b1;
            rsp_d_q <= lcl_data;
          end else begin
            pend_addr_q  <= cpu_req_addr;
            pend_wdata_q <= cpu_req_wdata;
            state_q      <= cpu_req_write ? CS_WRITE : CS_FILL;
          end
        end
        CS_FILL, CS_WRITE: if (bus_ack) begin
          rsp_v_q <= 1'b1;
          rsp_d_q <= fill_data;
          state_q <= CS_IDLE;
        end
        default: state_q <= CS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/snp_wt_ctrl_chk.sv
module snp_wt_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int ID_W   = 2,
  parameter int MY_ID  = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic              cpu_req_write,
  input logic              cpu_rsp_valid,
  input logic              bus_req_valid,
  input logic              bus_req_write,
  input logic [ADDR_W-1:0] bus_req_addr,
  input logic [DATA_W-1:0] bus_req_wdata,
  input logic              bus_ack,
  input logic              snp_valid,
  input logic [ID_W-1:0]   snp_id,
  input logic              ev_hit,
  input logic              ev_snp_kill,
  input logic              ev_snp_patch
);
  logic acc;
  assign acc = cpu_req_valid && cpu_req_ready;

  assert_reset_idle_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> cpu_req_ready && !bus_req_valid && !cpu_rsp_valid);

  assert_hit_local_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !cpu_req_write && ev_hit |=> cpu_rsp_valid && !bus_req_valid);

  assert_miss_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !cpu_req_write && !ev_hit |=> bus_req_valid && !bus_req_write);

  assert_write_through_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cpu_req_write |=> bus_req_valid && bus_req_write);

  assert_ack_response_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && bus_ack |=> cpu_rsp_valid && !bus_req_valid);

  assert_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> !cpu_req_ready);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_ack |=> bus_req_valid && $stable(bus_req_write)
      && $stable(bus_req_addr) && $stable(bus_req_wdata));

  assert_own_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_id == ID_W'(MY_ID) |-> !ev_snp_kill && !ev_snp_patch);
endmodule

bind snp_wt_ctrl snp_wt_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .MY_ID(MY_ID)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
  .cpu_req_write(cpu_req_write), .cpu_rsp_valid(cpu_rsp_valid),
  .bus_req_valid(bus_req_valid), .bus_req_write(bus_req_write),
  .bus_req_addr(bus_req_addr), .bus_req_wdata(bus_req_wdata), .bus_ack(bus_ack),
  .snp_valid(snp_valid), .snp_id(snp_id), .ev_hit(ev_hit),
  .ev_snp_kill(ev_snp_kill), .ev_snp_patch(ev_snp_patch)
);

// File: tb/sim_snp_wt_ctrl.sv
`timescale 1ns/1ps
module sim_bus_slave (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [7:0]  req_addr,
  input  logic [31:0] req_wdata,
  output logic        ack,
  output logic [31:0] rdata,
  input  logic        rw_valid,
  input  logic [7:0]  rw_addr,
  input  logic [31:0] rw_data,
  output int          rd_count
);
  logic [31:0] mem [256];
  logic        wait_q;
  initial for (int a = 0; a < 256; a++) mem[a] = {a[7:0], ~a[7:0], a[7:0] ^ 8'h3c, 8'h5a};
  always @(posedge clk) begin
    if (!rst_n) begin
      ack <= 1'b0; wait_q <= 1'b0; rd_count <= 0; rdata <= '0;
    end else begin
      ack <= 1'b0;
      if (rw_valid) mem[rw_addr] <= rw_data;
      if (req_valid && !ack) begin
        if (!wait_q) wait_q <= 1'b1;
        else begin
          wait_q <= 1'b0;
          ack    <= 1'b1;
          if (req_write) mem[req_addr] <= req_wdata;
          else begin
            rdata    <= mem[req_addr];
            rd_count <= rd_count + 1;
          end
        end
      end
    end
  end
endmodule

module sim_snp_wt_ctrl;
  localparam int MY = 0;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_v [2];
  logic        rdy [2], rsp_v [2], bus_v [2], bus_w [2], ack [2];
  logic [31:0] rsp_d [2], bus_wd [2], bus_rd [2];
  logic [7:0]  bus_a [2];
  int          rdc [2];
  logic        req_we = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        s_v = 1'b0, s_w = 1'b0;
  logic [1:0]  s_id = '0;
  logic [7:0]  s_a = '0;
  logic [31:0] s_d = '0;
  logic        mem_wr;
  assign mem_wr = s_v && s_w && (s_id != 2'(MY));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [31:0] exp_mem [256];
  logic [31:0] res_d [2];
  int          res_nrd [2];
  bit          res_stall_bad, res_timeout;

  for (genvar i = 0; i < 2; i++) begin : g_dut
    sim_bus_slave u_mem (
      .clk(clk), .rst_n(rst_n), .req_valid(bus_v[i]), .req_write(bus_w[i]),
      .req_addr(bus_a[i]), .req_wdata(bus_wd[i]), .ack(ack[i]), .rdata(bus_rd[i]),
      .rw_valid(mem_wr), .rw_addr(s_a), .rw_data(s_d), .rd_count(rdc[i]));
  end

  snp_wt_ctrl #(.UPDATE_MODE(1'b0), .MY_ID(MY)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req_valid(req_v[0]), .cpu_req_ready(rdy[0]),
    .cpu_req_write(req_we), .cpu_req_addr(req_addr), .cpu_req_wdata(req_wdata),
    .cpu_rsp_valid(rsp_v[0]), .cpu_rsp_rdata(rsp_d[0]), .bus_req_valid(bus_v[0]),
    .bus_req_write(bus_w[0]), .bus_req_addr(bus_a[0]), .bus_req_wdata(bus_wd[0]),
    .bus_ack(ack[0]), .bus_rdata(bus_rd[0]), .snp_valid(s_v), .snp_write(s_w),
    .snp_id(s_id), .snp_addr(s_a), .snp_wdata(s_d));

  snp_wt_ctrl #(.UPDATE_MODE(1'b1), .MY_ID(MY)) u1 (
    .clk(clk), .rst_n(rst_n), .cpu_req_valid(req_v[1]), .cpu_req_ready(rdy[1]),
    .cpu_req_write(req_we), .cpu_req_addr(req_addr), .cpu_req_wdata(req_wdata),
    .cpu_rsp_valid(rsp_v[1]), .cpu_rsp_rdata(rsp_d[1]), .bus_req_valid(bus_v[1]),
    .bus_req_write(bus_w[1]), .bus_req_addr(bus_a[1]), .bus_req_wdata(bus_wd[1]),
    .bus_ack(ack[1]), .bus_rdata(bus_rd[1]), .snp_valid(s_v), .snp_write(s_w),
    .snp_id(s_id), .snp_addr(s_a), .snp_wdata(s_d));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one processor access on both instances; optional snoop raised on the same edge
  task automatic access(input logic we, input logic [7:0] a, input logic [31:0] wd,
                        input bit with_snp, input logic [1:0] sid, input logic [31:0] sd);
    int base [2];
    bit acc_next [2], acc [2], got [2];
    int guard = 0;
    for (int i = 0; i < 2; i++) begin base[i] = rdc[i]; acc[i] = 0; got[i] = 0; end
    res_stall_bad = 0;
    @(negedge clk);
    req_we = we; req_addr = a; req_wdata = wd;
    req_v[0] = 1'b1; req_v[1] = 1'b1;
    if (with_snp) begin
      s_v = 1'b1; s_w = 1'b1; s_id = sid; s_a = a; s_d = sd;
      if (sid != 2'(MY)) exp_mem[a] = sd;
    end
    for (int i = 0; i < 2; i++) acc_next[i] = req_v[i] && rdy[i];
    while (!(got[0] && got[1]) && guard < 60) begin
      @(negedge clk);
      guard++;
      s_v = 1'b0;
      for (int i = 0; i < 2; i++) begin
        if (acc_next[i]) begin req_v[i] = 1'b0; acc[i] = 1; end
        if (rsp_v[i] && acc[i] && !got[i]) begin got[i] = 1; res_d[i] = rsp_d[i]; end
        if (acc[i] && !got[i] && bus_v[i] && (rdy[i] || bus_a[i] != a)) res_stall_bad = 1;
        acc_next[i] = req_v[i] && rdy[i];
      end
    end
    res_timeout = !(got[0] && got[1]);
    req_v[0] = 1'b0; req_v[1] = 1'b0;
    if (we) exp_mem[a] = wd;
    for (int i = 0; i < 2; i++) res_nrd[i] = rdc[i] - base[i];
  endtask

  task automatic snoop(input logic wr, input logic [1:0] sid, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    s_v = 1'b1; s_w = wr; s_id = sid; s_a = a; s_d = d;
    if (wr && sid != 2'(MY)) exp_mem[a] = d;
    @(negedge clk);
    s_v = 1'b0;
  endtask

  task automatic t_reset;
    for (int i = 0; i < 2; i++) begin
      check(rdy[i] && !bus_v[i] && !rsp_v[i], "R1 reset idle", {29'd0, rdy[i], bus_v[i], rsp_v[i]}, 32'h4);
    end
  endtask

  task automatic t_miss_then_hit;
    access(1'b0, 8'h12, '0, 0, '0, '0);
    check(res_nrd[0] == 1 && res_nrd[1] == 1, "R1 first read fetches", res_nrd[0], 1);
    check(res_d[0] == exp_mem[8'h12], "R3 fill data", res_d[0], exp_mem[8'h12]);
    check(!res_stall_bad && !res_timeout, "R5 stall during fill", {31'd0, res_stall_bad}, 0);
    access(1'b0, 8'h12, '0, 0, '0, '0);
    check(res_nrd[0] == 0 && res_nrd[1] == 0, "R2 hit without bus", res_nrd[0], 0);
    check(res_d[1] == exp_mem[8'h12], "R2 hit data", res_d[1], exp_mem[8'h12]);
  endtask

  task automatic t_write_through;
    access(1'b1, 8'h12, 32'hA5A5_0001, 0, '0, '0);
    check(g_dut[0].u_mem.mem[8'h12] == 32'hA5A5_0001, "R4 memory updated", g_dut[0].u_mem.mem[8'h12], 32'hA5A5_0001);
    check(!res_stall_bad && !res_timeout, "R5 stall during write", {31'd0, res_stall_bad}, 0);
    access(1'b0, 8'h12, '0, 0, '0, '0);
    check(res_nrd[0] == 0 && res_d[0] == 32'hA5A5_0001, "R4 written line hits", res_d[0], 32'hA5A5_0001);
    access(1'b1, 8'h33, 32'h0000_3333, 0, '0, '0);
    access(1'b0, 8'h33, '0, 0, '0, '0);
    check(res_nrd[1] == 0 && res_d[1] == 32'h0000_3333, "R4 write allocates", res_d[1], 32'h3333);
  endtask

  task automatic t_replace;
    access(1'b0, 8'h16, '0, 0, '0, '0);
    check(res_nrd[0] == 1 && res_d[0] == exp_mem[8'h16], "R6 new tag fetched", res_d[0], exp_mem[8'h16]);
    access(1'b0, 8'h12, '0, 0, '0, '0);
    check(res_nrd[0] == 1 && res_d[0] == 32'hA5A5_0001, "R6 old line evicted", res_nrd[0], 1);
  endtask

  task automatic t_remote_write;
    access(1'b0, 8'h21, '0, 0, '0, '0);
    snoop(1'b1, 2'd1, 8'h21, 32'h0000_0777);
    access(1'b0, 8'h21, '0, 0, '0, '0);
    check(res_nrd[0] == 1 && res_d[0] == 32'h777, "R7 invalidate then refetch", res_nrd[0], 1);
    check(res_nrd[1] == 0 && res_d[1] == 32'h777, "R8 update in place", res_d[1], 32'h777);
    access(1'b0, 8'h21, '0, 0, '0, '0);
    check(res_nrd[1] == 0, "R8 line stays valid", res_nrd[1], 0);
  endtask

  task automatic t_ignored;
    snoop(1'b1, 2'(MY), 8'h21, 32'hDEAD_BEEF);
    access(1'b0, 8'h21, '0, 0, '0, '0);
    check(res_nrd[0] == 0 && res_nrd[1] == 0 && res_d[0] == 32'h777 && res_d[1] == 32'h777,
          "R9 own id ignored", res_d[1], 32'h777);
    snoop(1'b0, 2'd2, 8'h21, 32'h1111_1111);
    access(1'b0, 8'h21, '0, 0, '0, '0);
    check(res_nrd[0] == 0 && res_d[0] == 32'h777, "R9 snooped read ignored", res_nrd[0], 0);
    snoop(1'b1, 2'd3, 8'h25, 32'h0000_2525);
    access(1'b0, 8'h21, '0, 0, '0, '0);
    check(res_nrd[0] == 0 && res_nrd[1] == 0 && res_d[1] == 32'h777, "R9 other tag ignored", res_d[1], 32'h777);
  endtask

  task automatic t_same_cycle;
    access(1'b0, 8'h21, '0, 1, 2'd1, 32'h0000_0999);
    check(res_nrd[0] == 1 && res_d[0] == 32'h999, "R10 snoop first invalidate", res_d[0], 32'h999);
    check(res_nrd[1] == 0 && res_d[1] == 32'h999, "R10 snoop first update", res_d[1], 32'h999);
  endtask

  initial begin
    for (int a = 0; a < 256; a++) exp_mem[a] = {a[7:0], ~a[7:0], a[7:0] ^ 8'h3c, 8'h5a};
    req_v[0] = 1'b0; req_v[1] = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_miss_then_hit;
    t_write_through;
    t_replace;
    t_remote_write;
    t_ignored;
    t_same_cycle;
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule